// File: doc/BRIEF.md
# I2S Master Clock Generator

This block turns one fast input clock into the three timing signals an I2S transmitter needs: an optional master clock, a bit clock and a word-select line. It also gives a one-cycle strobe that marks the start of every stereo frame. A prescaler divides the fast clock by an integer divisor. The divisor is formed from a multi-bit divide field and a single odd bit. Two mode inputs then shape the rest. One decides whether the master clock is driven. The other picks 16-bit or 32-bit channel slots.

With the master clock enabled, the bit clock is divided further from the prescaler output so that the master clock runs at 256 times the frame rate in both slot widths. With the master clock disabled, the prescaler output itself is the bit clock.

Settings are sampled once, on the clock edge at which the block leaves its disabled state. While the block runs, the waveforms depend only on that snapshot. An out-of-range divide field parks the block with all outputs low until enable is withdrawn. The serial data path and the source of the fast clock belong to other blocks.

Top module: `i2s_mclk_gen`

## Requirements
- R1: The prescale divisor is N = 2·DIV + ODD fast-clock cycles. In master-clock mode, `mclk_o` is periodic with period N.
- R2: Each prescaler period is high for ceil(N/2) cycles and then low for floor(N/2) cycles. For an odd N the high phase is one cycle longer, and the first running cycle is high.
- R3: DIV is valid only for 2 ≤ DIV ≤ 254. If enable starts the block with any other DIV, all four outputs stay low until enable is sampled low.
- R4: In master-clock mode, `bclk_o` has period 8·N and is high for its first 4·N cycles when `wide_mode`=0. When `wide_mode`=1 it has period 4·N and is high for its first 2·N cycles. Either way a frame lasts 256·N cycles.
- R5: With `mclk_mode`=0, `mclk_o` stays low and `bclk_o` follows the prescaler waveform of R2 with period N.
- R6: `ws_o` is low for the left slot and high for the right slot. It changes only in the cycle in which `bclk_o` falls, after every 16 bit-clock falls (`wide_mode`=0) or every 32 bit-clock falls (`wide_mode`=1).
- R7: `frame_o` is high for exactly one cycle: in the first running cycle, and in each cycle in which `ws_o` returns low.
- R8: DIV, ODD, `mclk_mode` and `wide_mode` are sampled only at start-up. Changes made while running have no effect until the next enable.
- R9: During reset, and from the cycle after enable is sampled low, all outputs are low. Each restart begins again from phase zero.
- R10: The first running cycle is the cycle right after the clock edge that samples enable high in the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; a rising request samples the settings |
| div_cfg | input | DIV_W | Integer divide field DIV |
| odd_cfg | input | 1 | Adds one cycle to the divisor |
| mclk_mode | input | 1 | 1: drive master clock, bit clock divided from it |
| wide_mode | input | 1 | 0: 16-bit slots, 1: 32-bit slots |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low for left channel |
| frame_o | output | 1 | One-cycle frame-start strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit divide field, 16/32-bit slots and a 256× master clock. It sweeps DIV over 2 to 4 with both odd settings in all four mode combinations. In every cycle of more than two full frames it compares all four outputs with a closed-form model of the phase count. This covers the even and odd high times, every bit-clock ratio, word-select placement and the frame strobe, as well as restarts from phase zero. Separate runs exercise the range edges of DIV (0, 1, 254, 255) and settings changed in mid-run.

// File: rtl/i2sclk_pkg.sv
package i2sclk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2
   } run_state_t;

   localparam int DEF_DIV_W       = 8;
   localparam int DEF_DIV_MIN     = 2;
   localparam int DEF_DIV_MAX     = 254;
   localparam int DEF_SLOT_NARROW = 16;
   localparam int DEF_SLOT_WIDE   = 32;
   localparam int DEF_MCLK_PER_FS = 256;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/i2sclk_cfg_latch.sv
module i2sclk_cfg_latch
   import i2sclk_pkg::*;
#(
   parameter int DIV_W   = DEF_DIV_W,
   parameter int DIV_MIN = DEF_DIV_MIN,
   parameter int DIV_MAX = DEF_DIV_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_in,
   input  logic             odd_in,
   input  logic             mclk_in,
   input  logic             wide_in,
   output logic             start,
   output logic             go,
   output logic             run,
   output logic [DIV_W-1:0] div_q,
   output logic             odd_q,
   output logic             mclk_q,
   output logic             wide_q
);

   localparam logic [DIV_W-1:0] LIM_LO = DIV_W'(DIV_MIN);
   localparam logic [DIV_W-1:0] LIM_HI = DIV_W'(DIV_MAX);

   generate
      if (DIV_MIN < 2) begin : g_bad_min
         $error("DIV_MIN must be at least 2");
      end
      if (DIV_MAX >= (1 << DIV_W) || DIV_MAX < DIV_MIN) begin : g_bad_max
         $error("DIV_MAX out of range for DIV_W");
      end
   endgenerate

   run_state_t state;
   logic       cfg_ok;

   assign cfg_ok = (div_in >= LIM_LO) && (div_in <= LIM_HI);
   assign run    = (state == ST_RUN);
   assign go     = run && en;
   assign start  = (state == ST_IDLE) && en && cfg_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         div_q  <= '0;
         odd_q  <= 1'b0;
         mclk_q <= 1'b0;
         wide_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (en) begin
                  div_q  <= div_in;
                  odd_q  <= odd_in;
                  mclk_q <= mclk_in;
                  wide_q <= wide_in;
                  state  <= cfg_ok ? ST_RUN : ST_HALT;
               end
            end
            default: begin
               if (!en) state <= ST_IDLE;
            end
         endcase
      end
   end

   // R8: the snapshot is frozen for as long as the block keeps running
   p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> ($stable(div_q) && $stable(odd_q) &&
                               $stable(mclk_q) && $stable(wide_q)));

   // R3: a parked block does not go back to running while enable stays high
   p_halt_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT && en) |=> (state == ST_HALT));

endmodule

// File: rtl/i2sclk_prescale.sv
module i2sclk_prescale #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             go,
   input  logic [DIV_W-1:0] div_q,
   input  logic             odd_q,
   output logic             pre_q,
   output logic             pc_last,
   output logic             pc_half
);

   localparam int N_W = DIV_W + 1;
   localparam logic [N_W-1:0] ONE = N_W'(1);

   logic [N_W-1:0] divisor;
   logic [N_W-1:0] hi_len;
   logic [N_W-1:0] pc;
   logic [N_W-1:0] hcnt;

   assign divisor = {div_q, 1'b0} + {{DIV_W{1'b0}}, odd_q};
   assign hi_len  = divisor - (divisor >> 1);
   assign pc_last = go && (pc == divisor - ONE);
   assign pc_half = go && (pc == hi_len - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc    <= '0;
         pre_q <= 1'b0;
      end else if (start) begin
         pc    <= '0;
         pre_q <= 1'b1;
      end else if (go) begin
         pc <= pc_last ? '0 : pc + ONE;
         if (pc_last)      pre_q <= 1'b1;
         else if (pc_half) pre_q <= 1'b0;
      end else begin
         pc    <= '0;
         pre_q <= 1'b0;
      end
   end

   // length of the current high phase, for the duty-cycle check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hcnt <= '0;
      else if (pre_q) hcnt <= hcnt + ONE;
      else            hcnt <= '0;
   end

   // R2: the high phase lasts ceil(N/2) cycles
   p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && $past(go) && $fell(pre_q)) |-> (hcnt == hi_len));

   // R1: the prescaler always starts a new period high
   p_period_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_last) |=> pre_q);

endmodule

// File: rtl/i2sclk_bitgen.sv
module i2sclk_bitgen
   import i2sclk_pkg::*;
#(
   parameter int RATIO_NARROW = 8,
   parameter int RATIO_WIDE   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic go,
   input  logic mclk_on,
   input  logic wide,
   input  logic pc_last,
   input  logic pc_half,
   output logic bclk_q,
   output logic bfall
);

   localparam int RMAX = max2(RATIO_NARROW, RATIO_WIDE);
   localparam int BC_W = (RMAX > 2) ? $clog2(RMAX) : 1;

   generate
      if (RATIO_NARROW < 2 || RATIO_WIDE < 2) begin : g_bad_ratio
         $error("bit-clock ratios must be at least 2");
      end
      if ((RATIO_NARROW % 2) != 0 || (RATIO_WIDE % 2) != 0) begin : g_odd_ratio
         $error("bit-clock ratios must be even");
      end
   endgenerate

   logic [BC_W-1:0] bc;
   logic [BC_W-1:0] last_m1;
   logic [BC_W-1:0] half_m1;
   logic            brise;

   always_comb begin
      if (!mclk_on) begin
         last_m1 = '0;
         half_m1 = '0;
      end else if (wide) begin
         last_m1 = BC_W'(RATIO_WIDE - 1);
         half_m1 = BC_W'(RATIO_WIDE / 2 - 1);
      end else begin
         last_m1 = BC_W'(RATIO_NARROW - 1);
         half_m1 = BC_W'(RATIO_NARROW / 2 - 1);
      end
   end

   assign bfall = go && (mclk_on ? (pc_last && bc == half_m1) : pc_half);
   assign brise = go && pc_last && (bc == last_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc     <= '0;
         bclk_q <= 1'b0;
      end else if (start) begin
         bc     <= '0;
         bclk_q <= 1'b1;
      end else if (go) begin
         if (pc_last) bc <= (bc == last_m1) ? '0 : bc + BC_W'(1);
         if (brise)      bclk_q <= 1'b1;
         else if (bfall) bclk_q <= 1'b0;
      end else begin
         bc     <= '0;
         bclk_q <= 1'b0;
      end
   end

   // R4: in divided mode the bit clock only moves on a prescaler period boundary
   p_bclk_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && mclk_on && !pc_last) |=> $stable(bclk_q));

endmodule

// File: rtl/i2sclk_wsgen.sv
module i2sclk_wsgen #(
   parameter int SLOT_NARROW = 16,
   parameter int SLOT_WIDE   = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic go,
   input  logic wide,
   input  logic bfall,
   output logic ws_q,
   output logic strobe_q
);

   localparam int SC_W = $clog2(2 * SLOT_WIDE);

   generate
      if (SLOT_NARROW < 1 || SLOT_WIDE < SLOT_NARROW) begin : g_bad_slot
         $error("slot widths must satisfy 1 <= narrow <= wide");
      end
   endgenerate

   logic [SC_W-1:0] bitc;
   logic [SC_W-1:0] bitc_nx;
   logic [SC_W-1:0] slot;
   logic [SC_W-1:0] frame_m1;

   assign slot     = wide ? SC_W'(SLOT_WIDE) : SC_W'(SLOT_NARROW);
   assign frame_m1 = wide ? SC_W'(2 * SLOT_WIDE - 1) : SC_W'(2 * SLOT_NARROW - 1);
   assign bitc_nx  = (bitc == frame_m1) ? '0 : bitc + SC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitc     <= '0;
         ws_q     <= 1'b0;
         strobe_q <= 1'b0;
      end else if (start) begin
         bitc     <= '0;
         ws_q     <= 1'b0;
         strobe_q <= 1'b1;
      end else if (go) begin
         strobe_q <= 1'b0;
         if (bfall) begin
            bitc     <= bitc_nx;
            ws_q     <= (bitc_nx >= slot);
            strobe_q <= (bitc_nx == '0);
         end
      end else begin
         bitc     <= '0;
         ws_q     <= 1'b0;
         strobe_q <= 1'b0;
      end
   end

   // R7: the frame strobe always marks the left slot
   p_strobe_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> !ws_q);

   // R7: the strobe is never longer than one cycle
   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |=> !strobe_q);

endmodule

// File: rtl/i2s_mclk_gen.sv
module i2s_mclk_gen
   import i2sclk_pkg::*;
#(
   parameter int DIV_W       = DEF_DIV_W,
   parameter int DIV_MIN     = DEF_DIV_MIN,
   parameter int DIV_MAX     = DEF_DIV_MAX,
   parameter int SLOT_NARROW = DEF_SLOT_NARROW,
   parameter int SLOT_WIDE   = DEF_SLOT_WIDE,
   parameter int MCLK_PER_FS = DEF_MCLK_PER_FS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic             odd_cfg,
   input  logic             mclk_mode,
   input  logic             wide_mode,
   output logic             mclk_o,
   output logic             bclk_o,
   output logic             ws_o,
   output logic             frame_o
);

   localparam int RATIO_NARROW = MCLK_PER_FS / (2 * SLOT_NARROW);
   localparam int RATIO_WIDE   = MCLK_PER_FS / (2 * SLOT_WIDE);

   generate
      if (RATIO_NARROW * 2 * SLOT_NARROW != MCLK_PER_FS) begin : g_bad_narrow
         $error("MCLK_PER_FS must be a multiple of two narrow slots");
      end
      if (RATIO_WIDE * 2 * SLOT_WIDE != MCLK_PER_FS) begin : g_bad_wide
         $error("MCLK_PER_FS must be a multiple of two wide slots");
      end
   endgenerate

   logic             start, go, run;
   logic [DIV_W-1:0] div_q;
   logic             odd_q, mclk_q, wide_q;
   logic             pre_q, pc_last, pc_half;
   logic             bclk_q, bfall;
   logic             ws_q, strobe_q;

   i2sclk_cfg_latch #(
      .DIV_W   (DIV_W),
      .DIV_MIN (DIV_MIN),
      .DIV_MAX (DIV_MAX)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .div_in  (div_cfg),
      .odd_in  (odd_cfg),
      .mclk_in (mclk_mode),
      .wide_in (wide_mode),
      .start   (start),
      .go      (go),
      .run     (run),
      .div_q   (div_q),
      .odd_q   (odd_q),
      .mclk_q  (mclk_q),
      .wide_q  (wide_q)
   );

   i2sclk_prescale #(
      .DIV_W (DIV_W)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .go      (go),
      .div_q   (div_q),
      .odd_q   (odd_q),
      .pre_q   (pre_q),
      .pc_last (pc_last),
      .pc_half (pc_half)
   );

   i2sclk_bitgen #(
      .RATIO_NARROW (RATIO_NARROW),
      .RATIO_WIDE   (RATIO_WIDE)
   ) u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .go      (go),
      .mclk_on (mclk_q),
      .wide    (wide_q),
      .pc_last (pc_last),
      .pc_half (pc_half),
      .bclk_q  (bclk_q),
      .bfall   (bfall)
   );

   i2sclk_wsgen #(
      .SLOT_NARROW (SLOT_NARROW),
      .SLOT_WIDE   (SLOT_WIDE)
   ) u_ws (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .go       (go),
      .wide     (wide_q),
      .bfall    (bfall),
      .ws_q     (ws_q),
      .strobe_q (strobe_q)
   );

   assign mclk_o  = pre_q & mclk_q;
   assign bclk_o  = bclk_q;
   assign ws_o    = ws_q;
   assign frame_o = strobe_q;

   // R9: nothing toggles unless the block is running
   p_quiet_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!mclk_o && !bclk_o && !ws_o && !frame_o));

   // R5: without master clock the bit clock is the prescaler waveform
   p_bclk_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !mclk_q) |-> (bclk_o == pre_q));

   // R6: word select only moves together with a falling bit clock
   p_ws_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (ws_o != $past(ws_o))) |-> $fell(bclk_o));

endmodule

// File: tb/sim_i2s_mclk_gen.sv
module sim_i2s_mclk_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] div_cfg = 8'd0;
   logic       odd_cfg = 1'b0;
   logic       mclk_mode = 1'b0;
   logic       wide_mode = 1'b0;
   logic       mclk_o, bclk_o, ws_o, frame_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2s_mclk_gen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .div_cfg   (div_cfg),
      .odd_cfg   (odd_cfg),
      .mclk_mode (mclk_mode),
      .wide_mode (wide_mode),
      .mclk_o    (mclk_o),
      .bclk_o    (bclk_o),
      .ws_o      (ws_o),
      .frame_o   (frame_o)
   );

   // expected {mclk, bclk, ws, frame} in running cycle t
   function automatic logic [3:0] model(input int t, input int dv, input bit od,
                                        input bit mm, input bit wd);
      int  n, h, r, w, p, hb, falls;
      bit  pre, bc, ws, fr;
      n   = 2 * dv + int'(od);
      h   = n - n / 2;
      r   = mm ? (wd ? 4 : 8) : 1;
      w   = wd ? 32 : 16;
      p   = n * r;
      hb  = (r == 1) ? h : p / 2;
      pre = (t % n) < h;
      bc  = (r == 1) ? pre : (((t / n) % r) < r / 2);
      falls = (t < hb) ? 0 : (t - hb) / p + 1;
      ws  = (falls % (2 * w)) >= w;
      fr  = (t == 0) || (t >= hb && ((t - hb) % p) == 0 && (falls % (2 * w)) == 0);
      return {mm & pre, bc, ws, fr};
   endfunction

   task automatic check_vec(input logic [3:0] act, input logic [3:0] exp_v,
                            input string tag, input int t);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s t=%0d actual=%b expected=%b (mclk,bclk,ws,frame)",
                  tag, t, act, exp_v);
      end
   endtask

   task automatic stop_and_check_quiet();
      en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_vec({mclk_o, bclk_o, ws_o, frame_o}, 4'b0000, "R9 stop", -1);
   endtask

   // start at a falling edge, compare every cycle against the model
   task automatic run_cfg(input int dv, input bit od, input bit mm, input bit wd,
                          input int ncyc, input int chg_at);
      int fails;
      logic [3:0] e, a;
      string tag;
      fails = 0;
      div_cfg = 8'(dv); odd_cfg = od; mclk_mode = mm; wide_mode = wd;
      en = 1'b1;
      @(posedge clk);
      for (int t = 0; t < ncyc; t++) begin
         @(negedge clk);
         e = model(t, dv, od, mm, wd);
         a = {mclk_o, bclk_o, ws_o, frame_o};
         if (t == 0)                tag = "R10";
         else if (chg_at >= 0 && t > chg_at) tag = "R8";
         else if (a[3] !== e[3])    tag = od ? "R2" : "R1";
         else if (a[2] !== e[2])    tag = mm ? "R4" : "R5";
         else if (a[1] !== e[1])    tag = "R6";
         else                       tag = "R7";
         check_vec(a, e, tag, t);
         if (a !== e) fails++;
         if (t == chg_at) begin
            div_cfg = 8'(dv + 1); odd_cfg = ~od; mclk_mode = ~mm; wide_mode = ~wd;
         end
         if (fails >= 3) break;
      end
      stop_and_check_quiet();
   endtask

   task automatic run_invalid(input int dv);
      div_cfg = 8'(dv); odd_cfg = 1'b1; mclk_mode = 1'b1; wide_mode = 1'b0;
      en = 1'b1;
      @(posedge clk);
      for (int t = 0; t < 60; t++) begin
         @(negedge clk);
         if (t == 30) div_cfg = 8'd3;  // a valid value while parked: still quiet
         check_vec({mclk_o, bclk_o, ws_o, frame_o}, 4'b0000, "R3 invalid DIV", t);
      end
      stop_and_check_quiet();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check_vec({mclk_o, bclk_o, ws_o, frame_o}, 4'b0000, "R9 reset", -1);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec({mclk_o, bclk_o, ws_o, frame_o}, 4'b0000, "R9 idle", -1);

      // sweep: R1 R2 R4 R5 R6 R7 R10, restarts cover R9
      for (int dv = 2; dv <= 4; dv++) begin
         for (int m = 0; m < 8; m++) begin
            int n, flen;
            bit od, mm, wd;
            od = m[0]; mm = m[1]; wd = m[2];
            n = 2 * dv + int'(od);
            flen = mm ? 256 * n : (wd ? 64 : 32) * n;
            run_cfg(dv, od, mm, wd, 2 * flen + 40, -1);
         end
      end

      // R8: settings changed while running are ignored, then used at next enable
      run_cfg(3, 1'b1, 1'b1, 1'b0, 2 * 256 * 7 + 40, 200);
      run_cfg(4, 1'b0, 1'b0, 1'b1, 2 * 64 * 8 + 40, -1);

      // R3: range edges
      run_invalid(0);
      run_invalid(1);
      run_invalid(255);
      run_cfg(254, 1'b1, 1'b0, 1'b0, 3000, -1);
      run_cfg(254, 1'b0, 1'b1, 1'b1, 3000, -1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule